// File: doc/BRIEF.md
# Two-Queue Weighted Transmit Scheduler

This block decides which of two transmit queues, high and low priority, supplies the next packet. It grants one packet at a time and waits for the transmitter's completion strobe before it grants the next. When both queues have work, a 3-bit weight code sets how many high-priority packets go out for each low-priority one. The top code selects strict priority instead.

A host drives per-queue start and stop pulses and a global abort pulse. A stop lets the frame in flight finish and then reports completion with an end pulse. A queue that is running but has nothing pending also closes with an end pulse. An abort drops everything at once and reports no completion.

The controller has three states. `ST_IDLE` waits for an eligible queue. `ST_SEND` covers one packet in flight. `ST_ABORT` lasts one cycle while the abort is being taken. The transitions are:

- grant: `ST_IDLE` to `ST_SEND`, when a queue is picked.
- done: `ST_SEND` to `ST_IDLE`, on `pkt_done`.
- kill: any state to `ST_ABORT`, on `cmd_abort`.
- settle: `ST_ABORT` to `ST_IDLE`, always after one cycle.

Top module: `txq_wrr_sched`

## Requirements
- R1: A queue is eligible when its run bit is set and its pending input is high. With both queues eligible and `weight_code` 0 to 6, the block grants a run of high packets and then one low packet. The run is 1 long for code 0 and 2×code long otherwise (1, 2, 4, 6, 8, 10, 12).
- R2: With `weight_code` = 7, a low grant is given only in a decision where the high queue is not eligible.
- R3: The high-packet count clears in any cycle where the high queue is not eligible. After the high queue drains, a new round starts from zero.
- R4: Outside strict mode, if only the low queue is eligible, the low queue is granted at once, whatever the count.
- R5: Grants are one-cycle pulses, and at most one is high at a time. A decision is made only in `ST_IDLE`. The grant pulse appears on the cycle after that decision. No further grant appears until the cycle after `pkt_done` has been taken.
- R6: A start pulse sets the queue's run bit and cancels a pending stop. A stop pulse clears the run bit. If start and stop arrive in the same cycle, start wins. With no pulse, the run bit holds.
- R7: A stop issued while that queue's frame is in flight completes only after the frame ends. It then gives a one-cycle end pulse for that queue. If no frame of that queue is in flight, the pulse comes one cycle after the stop.
- R8: A queue whose run bit is set, whose pending input is low, and which has no frame in flight clears its run bit and gives a one-cycle end pulse.
- R9: An abort sends the block to `ST_ABORT`, with `abort_busy` high for exactly that one cycle. It clears both run bits, any pending stops and the count. It gives no end pulse. Other commands in that cycle are ignored.
- R10: After reset, every output is low.
- R11: `tx_busy` is high from the grant pulse until the cycle after `pkt_done` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_pend | input | 1 | High queue has packets waiting |
| lo_pend | input | 1 | Low queue has packets waiting |
| pkt_done | input | 1 | Transmitter finished the granted packet |
| weight_code | input | 3 | High-to-low weight code (7 means strict) |
| cmd_start_hi | input | 1 | Start pulse, high queue |
| cmd_stop_hi | input | 1 | Stop pulse, high queue |
| cmd_start_lo | input | 1 | Start pulse, low queue |
| cmd_stop_lo | input | 1 | Stop pulse, low queue |
| cmd_abort | input | 1 | Abort pulse |
| grant_hi | output | 1 | One-cycle grant to the high queue |
| grant_lo | output | 1 | One-cycle grant to the low queue |
| run_hi | output | 1 | High queue running |
| run_lo | output | 1 | Low queue running |
| tx_busy | output | 1 | Packet in flight |
| abort_busy | output | 1 | Abort in progress; self-clearing |
| end_hi_irq | output | 1 | End pulse, high queue |
| end_lo_irq | output | 1 | End pulse, low queue |

## Verification
Two events can collide: a stop written for a queue, and a scheduling decision or packet completion for that same queue, both landing on one clock edge. The bench provokes this by writing stop on the edge where a grant for that queue is being decided, and again while that queue's frame is in flight with completion delays of zero to several cycles. A behavioural model then judges that the grant still goes out, and that the end pulse appears only after the frame finishes. Abort is also fired on edges where `pkt_done` or a grant decision falls, to show that abort wins and raises no end pulse.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_ABORT = 2'd2
    } sched_state_e;

    localparam int NUM_Q = 2;
    localparam int Q_HI  = 0;
    localparam int Q_LO  = 1;
endpackage

// File: rtl/txq_credit_arb.sv
module txq_credit_arb #(
    parameter int CODE_W   = 3,
    parameter int CREDIT_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elig_hi,
    input  logic              elig_lo,
    input  logic [CODE_W-1:0] weight_code,
    input  logic              decide,
    input  logic              clear,
    output logic              pick_hi,
    output logic              pick_lo
);
    logic [CREDIT_W-1:0] credit_q;
    logic [CREDIT_W-1:0] limit;
    logic                strict;

    assign strict = (weight_code == '1);
    assign limit  = (weight_code == '0) ? CREDIT_W'(1)
                                        : CREDIT_W'({weight_code, 1'b0});

    always_comb begin
        pick_hi = elig_hi && (strict || !elig_lo || (credit_q < limit));
        pick_lo = elig_lo && !pick_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else if (clear) begin
            credit_q <= '0;
        end else if (decide && pick_hi) begin
            if (credit_q != '1) credit_q <= credit_q + 1'b1;
        end else if ((decide && pick_lo) || !elig_hi) begin
            credit_q <= '0;
        end
    end

    assert_credit_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !elig_hi |=> (credit_q == '0));
endmodule

// File: rtl/txq_queue_ctrl.sv
module txq_queue_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic wr_stop,
    input  logic abort,
    input  logic pend,
    input  logic idle_pt,
    output logic run,
    output logic end_irq
);
    logic stop_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run       <= 1'b0;
            stop_pend <= 1'b0;
            end_irq   <= 1'b0;
        end else begin
            end_irq <= 1'b0;
            if (abort) begin
                run       <= 1'b0;
                stop_pend <= 1'b0;
            end else if (wr_start) begin
                run       <= 1'b1;
                stop_pend <= 1'b0;
            end else if (wr_stop) begin
                run       <= 1'b0;
                stop_pend <= 1'b1;
            end else if (idle_pt && stop_pend) begin
                stop_pend <= 1'b0;
                end_irq   <= 1'b1;
            end else if (idle_pt && run && !pend) begin
                run     <= 1'b0;
                end_irq <= 1'b1;
            end
        end
    end

    assert_start_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !abort) |=> (run && !end_irq));
    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stop && !wr_start && !abort) |=> !run);
    assert_stop_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend && !idle_pt && !abort && !wr_start) |=> (stop_pend && !end_irq));
endmodule

// File: rtl/txq_wrr_sched.sv
module txq_wrr_sched
    import txq_sched_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_pend,
    input  logic              lo_pend,
    input  logic              pkt_done,
    input  logic [CODE_W-1:0] weight_code,
    input  logic              cmd_start_hi,
    input  logic              cmd_stop_hi,
    input  logic              cmd_start_lo,
    input  logic              cmd_stop_lo,
    input  logic              cmd_abort,
    output logic              grant_hi,
    output logic              grant_lo,
    output logic              run_hi,
    output logic              run_lo,
    output logic              tx_busy,
    output logic              abort_busy,
    output logic              end_hi_irq,
    output logic              end_lo_irq
);
    sched_state_e     state_q, state_d;
    logic             cur_lo_q;
    logic             decide, pick_hi, pick_lo;
    logic [NUM_Q-1:0] start_v, stop_v, pend_v, idle_v, run_v, irq_v;

    assign start_v = {cmd_start_lo, cmd_start_hi};
    assign stop_v  = {cmd_stop_lo, cmd_stop_hi};
    assign pend_v  = {lo_pend, hi_pend};
    assign decide  = (state_q == ST_IDLE) && !cmd_abort;

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
            assign idle_v[q] = !((state_q == ST_SEND) && (cur_lo_q == (q == Q_LO)));
            txq_queue_ctrl u_qctl (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_start (start_v[q]),
                .wr_stop  (stop_v[q]),
                .abort    (cmd_abort),
                .pend     (pend_v[q]),
                .idle_pt  (idle_v[q]),
                .run      (run_v[q]),
                .end_irq  (irq_v[q])
            );
        end
    endgenerate

    assign run_hi     = run_v[Q_HI];
    assign run_lo     = run_v[Q_LO];
    assign end_hi_irq = irq_v[Q_HI];
    assign end_lo_irq = irq_v[Q_LO];

    txq_credit_arb #(.CODE_W(CODE_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .elig_hi     (run_v[Q_HI] && hi_pend),
        .elig_lo     (run_v[Q_LO] && lo_pend),
        .weight_code (weight_code),
        .decide      (decide),
        .clear       (cmd_abort),
        .pick_hi     (pick_hi),
        .pick_lo     (pick_lo)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_abort) begin
            state_d = ST_ABORT;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (pick_hi || pick_lo) state_d = ST_SEND;
                ST_SEND:  if (pkt_done) state_d = ST_IDLE;
                ST_ABORT: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_hi <= 1'b0;
            grant_lo <= 1'b0;
            cur_lo_q <= 1'b0;
        end else begin
            grant_hi <= decide && pick_hi;
            grant_lo <= decide && pick_lo;
            if (decide && pick_hi) cur_lo_q <= 1'b0;
            else if (decide && pick_lo) cur_lo_q <= 1'b1;
        end
    end

    assign tx_busy    = (state_q == ST_SEND);
    assign abort_busy = (state_q == ST_ABORT);

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_hi, grant_lo}));
    assert_no_regrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !pkt_done && !cmd_abort) |=> (!grant_hi && !grant_lo));
    assert_grant_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_hi || grant_lo) |-> tx_busy);
    assert_abort_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> (abort_busy && !tx_busy && !run_hi && !run_lo && !end_hi_irq && !end_lo_irq));
    assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_busy && !cmd_abort) |=> !abort_busy);
    assert_strict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && (weight_code == '1) && run_hi && hi_pend) |=> grant_hi);
    assert_lo_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && run_lo && lo_pend && !(run_hi && hi_pend)) |=> grant_lo);
endmodule

// File: tb/txq_wrr_sched_tb.sv
module txq_wrr_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_pend = 1'b0, lo_pend = 1'b0, pkt_done = 1'b0;
    logic [2:0] weight_code = 3'd0;
    logic       cmd_start_hi = 1'b0, cmd_stop_hi = 1'b0;
    logic       cmd_start_lo = 1'b0, cmd_stop_lo = 1'b0, cmd_abort = 1'b0;
    logic       grant_hi, grant_lo, run_hi, run_lo, tx_busy, abort_busy;
    logic       end_hi_irq, end_lo_irq;

    int total = 0, failed = 0;
    int dly = 1, tmr = 0, hcount = 0;
    int runs[$];
    bit done_flag = 0;

    always #10 clk = ~clk;

    txq_wrr_sched dut_i (
        .clk(clk), .rst_n(rst_n), .hi_pend(hi_pend), .lo_pend(lo_pend),
        .pkt_done(pkt_done), .weight_code(weight_code),
        .cmd_start_hi(cmd_start_hi), .cmd_stop_hi(cmd_stop_hi),
        .cmd_start_lo(cmd_start_lo), .cmd_stop_lo(cmd_stop_lo),
        .cmd_abort(cmd_abort), .grant_hi(grant_hi), .grant_lo(grant_lo),
        .run_hi(run_hi), .run_lo(run_lo), .tx_busy(tx_busy),
        .abort_busy(abort_busy), .end_hi_irq(end_hi_irq), .end_lo_irq(end_lo_irq)
    );

    // behavioural reference model
    int m_st, m_credit, lim;
    bit m_cur, m_gh, m_gl, eh, el, gh, gl, idle_q;
    bit [1:0] m_run, m_stp, m_irq, st_v, sp_v, pd_v;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_credit = 0; m_cur = 0; m_gh = 0; m_gl = 0;
            m_run = 0; m_stp = 0; m_irq = 0;
        end else begin
            st_v = {cmd_start_lo, cmd_start_hi};
            sp_v = {cmd_stop_lo, cmd_stop_hi};
            pd_v = {lo_pend, hi_pend};
            eh = m_run[0] && hi_pend;
            el = m_run[1] && lo_pend;
            lim = (weight_code == 0) ? 1 : 2 * int'(weight_code);
            gh = 0; gl = 0;
            if (m_st == 0 && !cmd_abort) begin
                if (eh && (weight_code == 7 || !el || m_credit < lim)) gh = 1;
                else if (el) gl = 1;
            end
            if (cmd_abort) m_credit = 0;
            else if (gh) m_credit = (m_credit < 15) ? m_credit + 1 : 15;
            else if (gl || !eh) m_credit = 0;
            for (int q = 0; q < 2; q++) begin
                idle_q = !(m_st == 1 && m_cur == q[0]);
                m_irq[q] = 0;
                if (cmd_abort) begin m_run[q] = 0; m_stp[q] = 0; end
                else if (st_v[q]) begin m_run[q] = 1; m_stp[q] = 0; end
                else if (sp_v[q]) begin m_run[q] = 0; m_stp[q] = 1; end
                else if (idle_q && m_stp[q]) begin m_stp[q] = 0; m_irq[q] = 1; end
                else if (idle_q && m_run[q] && !pd_v[q]) begin m_run[q] = 0; m_irq[q] = 1; end
            end
            if (cmd_abort) m_st = 2;
            else if (m_st == 0) m_st = (gh || gl) ? 1 : 0;
            else if (m_st == 1) m_st = pkt_done ? 0 : 1;
            else m_st = 0;
            if (gh) m_cur = 0;
            if (gl) m_cur = 1;
            m_gh = gh; m_gl = gl;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: compare at negedge, clear pulses, run the transmitter responder
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R5 grant_hi", grant_hi, m_gh);
        chk("R5 grant_lo", grant_lo, m_gl);
        chk("R6 run_hi", run_hi, m_run[0]);
        chk("R6 run_lo", run_lo, m_run[1]);
        chk("R7 end_hi_irq", end_hi_irq, m_irq[0]);
        chk("R7 end_lo_irq", end_lo_irq, m_irq[1]);
        chk("R11 tx_busy", tx_busy, m_st == 1);
        chk("R9 abort_busy", abort_busy, m_st == 2);
        if (grant_hi) hcount++;
        if (grant_lo) begin runs.push_back(hcount); hcount = 0; end
        cmd_start_hi = 0; cmd_stop_hi = 0; cmd_start_lo = 0; cmd_stop_lo = 0; cmd_abort = 0;
        if (grant_hi || grant_lo) tmr = dly;
        pkt_done = 0;
        if (tx_busy) begin
            if (tmr == 0) pkt_done = 1;
            else tmr--;
        end
    endtask

    task automatic do_abort();
        cmd_abort = 1; cyc(); cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        chk("R10 outputs after reset",
            {grant_hi, grant_lo, run_hi, run_lo, tx_busy, abort_busy, end_hi_irq, end_lo_irq}, 0);

        // R1: run length per weight code
        for (int c = 0; c < 7; c++) begin
            do_abort();
            weight_code = c[2:0]; dly = 1;
            hi_pend = 1; lo_pend = 1;
            runs.delete(); hcount = 0;
            cmd_start_hi = 1; cmd_start_lo = 1; cyc();
            for (int k = 0; k < 400 && runs.size() < 3; k++) cyc();
            chk("R1 low grants seen", runs.size(), 3);
            for (int r = 0; r < 3 && r < runs.size(); r++)
                chk("R1 high run length", runs[r], (c == 0) ? 1 : 2 * c);
        end

        // R2: strict priority
        do_abort();
        weight_code = 7; hi_pend = 1; lo_pend = 1; runs.delete(); hcount = 0;
        cmd_start_hi = 1; cmd_start_lo = 1; cyc();
        for (int k = 0; k < 80; k++) cyc();
        chk("R2 no low grant while high eligible", runs.size(), 0);
        chk("R2 high grants flowed", (hcount > 10) ? 1 : 0, 1);
        hi_pend = 0;
        for (int k = 0; k < 10 && runs.size() == 0; k++) cyc();
        chk("R2 low granted once high empty", runs.size(), 1);

        // R3: count cleared when high drains
        do_abort();
        weight_code = 2; hi_pend = 1; lo_pend = 0; runs.delete(); hcount = 0;
        cmd_start_hi = 1; cyc();
        for (int k = 0; k < 40 && hcount < 2; k++) cyc();
        hi_pend = 0;
        for (int k = 0; k < 8; k++) cyc();
        chk("R3 high queue drained", run_hi, 0);
        hi_pend = 1; lo_pend = 1; runs.delete(); hcount = 0;
        cmd_start_hi = 1; cmd_start_lo = 1; cyc();
        for (int k = 0; k < 60 && runs.size() < 1; k++) cyc();
        chk("R3 fresh round length", (runs.size() > 0) ? runs[0] : -1, 4);

        // R4: only low eligible gets served immediately
        do_abort();
        weight_code = 6; hi_pend = 0; lo_pend = 1;
        cmd_start_lo = 1; cyc();
        cyc();
        chk("R4 low granted without waiting", grant_lo, 1);

        // R6: start/stop command semantics
        do_abort();
        hi_pend = 0; lo_pend = 1;
        cmd_start_lo = 1; cmd_stop_lo = 1; cyc();
        chk("R6 start wins over stop", run_lo, 1);
        for (int k = 0; k < 6; k++) cyc();
        chk("R6 run held without command", run_lo, 1);

        // R7: stop waits for the frame in flight
        do_abort();
        dly = 5; hi_pend = 1; lo_pend = 0;
        cmd_start_hi = 1; cyc();
        for (int k = 0; k < 5 && !grant_hi; k++) cyc();
        cmd_stop_hi = 1; cyc();
        chk("R7 no end pulse mid-frame", end_hi_irq, 0);
        chk("R7 run cleared by stop", run_hi, 0);
        begin
            bit seen = 0, busy_at = 1;
            for (int k = 0; k < 20 && !seen; k++) begin
                cyc();
                if (end_hi_irq) begin seen = 1; busy_at = tx_busy; end
            end
            chk("R7 end pulse after frame", seen, 1);
            chk("R7 frame finished at end pulse", busy_at, 0);
        end

        // R8: drained running queue closes itself
        do_abort();
        dly = 1; hi_pend = 0; lo_pend = 0;
        cmd_start_lo = 1; cyc();
        chk("R8 run set by start", run_lo, 1);
        cyc();
        chk("R8 run cleared on drain", run_lo, 0);
        chk("R8 end pulse on drain", end_lo_irq, 1);

        // R9: abort during a frame
        dly = 6; hi_pend = 1; lo_pend = 1; weight_code = 1;
        cmd_start_hi = 1; cmd_start_lo = 1; cyc();
        for (int k = 0; k < 5 && !tx_busy; k++) cyc();
        cmd_abort = 1; cyc();
        chk("R9 abort flag raised", abort_busy, 1);
        chk("R9 transfer dropped", tx_busy, 0);
        cyc();
        chk("R9 abort flag self-clears", abort_busy, 0);
        chk("R9 no end pulse", {end_hi_irq, end_lo_irq}, 0);

        // mixed stimulus against the model, including same-edge collisions
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if ((k % 37) == 0) begin hi_pend = $urandom_range(0, 1); lo_pend = $urandom_range(0, 1); end
            if ((k % 211) == 0) weight_code = 3'($urandom_range(0, 7));
            if ((k % 53) == 0) dly = $urandom_range(0, 3);
            if (r < 4) cmd_start_hi = 1;
            else if (r < 8) cmd_start_lo = 1;
            else if (r < 10) cmd_stop_hi = 1;
            else if (r < 12) cmd_stop_lo = 1;
            else if (r < 13) cmd_abort = 1;
            else if (r < 14) begin cmd_start_hi = 1; cmd_stop_hi = 1; end
            if (tx_busy && pkt_done && r > 90) cmd_stop_hi = 1;
            cyc();
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            total++; failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule